// File: doc/BRIEF.md
# Socket Status-Change Interrupt Controller

This block watches the five status lines of one card socket (card present, write protect, ready and two battery-voltage sense lines), synchronises them, and records any change on an unmasked line as a status-change flag. It also records single-cycle event pulses from neighbouring logic: I/O check, error, programming-timer expiry, interlock change and stop-CPU. All six flags live in one byte-wide control/status register.

Software reaches three byte registers over a simple register bus: a live status view, the flag register and an interrupt enable register. Writes to the flag register carry a two-bit qualifier in their low bits that chooses between setting, clearing or loading the flags. The enable register gates four of the flags onto a single interrupt request, and its low two bits choose how the request pin is driven. The pin comes out as three signals: a level, an output enable and an open-drain indication, for the pad ring to combine.

Top module: `sktchg_irq_ctrl`

## Requirements
- R1: After reset, the flag register and the enable register read 0x00, and all three pin outputs are low (high-impedance mode).
- R2: The status register (select 0) shows card present in bit 7, write protect in bit 6, ready in bit 5, battery line 2 in bit 4 and battery line 1 in bit 3, bits 2:0 reading 0; each input appears after two clock edges of synchronisation.
- R3: A change of any status line, in either direction (ready falling and rising included), sets flag bit 6 (status change) of the flag register (select 1) on the third clock edge after the input moves.
- R4: Mask input bits 4:0 line up with status bits 7:3 in the same order; a mask bit at 1 stops changes on that line from setting bit 6.
- R5: A write to the flag register acts by data bits 1:0: 10 ORs data bits 7:2 into the flags, 01 clears the flags whose data bits are 1, 11 loads data bits 7:2, 00 leaves the flags unchanged; bits 1:0 read as 0.
- R6: Event pulses set flag bits 7 (I/O check), 5 (error), 4 (program timer), 3 (interlock) and 2 (stop-CPU) on the clock edge where they are high.
- R7: A hardware event in the same cycle as a software write that would clear or overwrite its flag leaves the flag set.
- R8: Enable register (select 2) bits 6, 5, 4, 3 gate flag bits 6, 5, 4, 3 onto the request; bits 7 and 2 are reserved and always read 0.
- R9: Enable bits 1:0 choose the pin drive: 00 all outputs low; 01 open-drain flag high, level low, output enable equal to the request; 10 enable high, level equal to the inverted request; 11 enable high, level equal to the request.
- R10: The request is active while any gated flag is set and goes inactive right after the clock edge of the write that clears the last gated flag; flag bits 7 and 2 never drive it.
- R11: Status lines held steady through reset do not set the change flag once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 2 | Register select: 0 status, 1 flags, 2 enable |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| card_det_i | input | 1 | Card present status line (asynchronous) |
| wprot_i | input | 1 | Write protect status line (asynchronous) |
| ready_i | input | 1 | Card ready status line (asynchronous) |
| batt2_i | input | 1 | Battery sense line 2 (asynchronous) |
| batt1_i | input | 1 | Battery sense line 1 (asynchronous) |
| chg_mask_i | input | 5 | Per-line change mask, bit 4 card present down to bit 0 battery line 1 |
| ev_iochk_i | input | 1 | I/O check event pulse |
| ev_err_i | input | 1 | Error event pulse |
| ev_ptimer_i | input | 1 | Programming timer event pulse |
| ev_ilock_i | input | 1 | Interlock change event pulse |
| ev_stopcpu_i | input | 1 | Stop-CPU event pulse |
| irq_level_o | output | 1 | Request pin drive level |
| irq_oe_o | output | 1 | Request pin output enable |
| irq_od_o | output | 1 | Request pin is in open-drain mode |

## Verification
The collision that matters is a hardware event landing in the same cycle as a software write to the flag register that would clear or overwrite that flag. The bench raises the interlock pulse together with a clear-all write, and the error pulse together with a load of zero, and expects the event's flag to read back set afterwards. The clearing of the last gated flag is also timed edge-exactly: the pin is sampled with the clearing write on the bus before its edge, where the request must still be active, and again right after, where it must be inactive.

// File: rtl/sktchg_pkg.sv
package sktchg_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_STAT = 5;
    localparam int NUM_FLAG = 6;
    localparam int NUM_GATE = 4;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_FLAGS  = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        QUAL_NONE  = 2'b00,
        QUAL_CLEAR = 2'b01,
        QUAL_SET   = 2'b10,
        QUAL_LOAD  = 2'b11
    } wr_qual_e;

    typedef enum logic [1:0] {
        PIN_HIZ     = 2'b00,
        PIN_OD_LOW  = 2'b01,
        PIN_TP_LOW  = 2'b10,
        PIN_TP_HIGH = 2'b11
    } pin_mode_e;

    // Order matches status register bits 7:3.
    typedef struct packed {
        logic card_det;
        logic wprot;
        logic ready;
        logic batt2;
        logic batt1;
    } stat_t;

    // Order matches flag register bits 7:2.
    typedef struct packed {
        logic io_check;
        logic stat_chg;
        logic error;
        logic prog_tmr;
        logic intlock;
        logic stop_cpu;
    } flags_t;

    typedef struct packed {
        logic level;
        logic oe;
        logic od;
    } pin_t;

    function automatic flags_t apply_write(flags_t cur, logic [DATA_W-1:0] wd);
        flags_t din;
        din = flags_t'(wd[DATA_W-1:2]);
        case (wr_qual_e'(wd[1:0]))
            QUAL_SET:   return flags_t'(cur | din);
            QUAL_CLEAR: return flags_t'(cur & ~din);
            QUAL_LOAD:  return din;
            default:    return cur;
        endcase
    endfunction

    function automatic pin_t drive_pin(pin_mode_e m, logic req);
        pin_t p;
        p = '0;
        case (m)
            PIN_OD_LOW:  begin p.od = 1'b1; p.oe = req;  p.level = 1'b0; end
            PIN_TP_LOW:  begin p.oe = 1'b1; p.level = ~req; end
            PIN_TP_HIGH: begin p.oe = 1'b1; p.level = req;  end
            default:     p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sktchg_sync.sv
module sktchg_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] toggled_o
);
    localparam int PRIME_MAX = STAGES + 1;
    localparam int PRIME_W   = $clog2(PRIME_MAX + 1);

    logic [STAGES-1:0][WIDTH-1:0] pipe_q;
    logic [WIDTH-1:0]             prev_q;
    logic [PRIME_W-1:0]           prime_q;
    logic                         primed;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) begin
                pipe_q[s] <= pipe_q[s-1];
            end
        end
    end

    // Change detection is held off until the pipeline and the previous
    // sample both carry real input values.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            prime_q <= '0;
        end else begin
            prev_q <= pipe_q[STAGES-1];
            if (!primed) prime_q <= prime_q + 1'b1;
        end
    end

    assign primed = (prime_q == PRIME_W'(PRIME_MAX));
    assign sync_o = pipe_q[STAGES-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        assign toggled_o[i] = primed & (pipe_q[STAGES-1][i] ^ prev_q[i]);
    end

endmodule

// File: rtl/sktchg_flags.sv
module sktchg_flags
    import sktchg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  flags_t            hw_set_i,
    output flags_t            flags_o
);
    flags_t flags_q;
    flags_t after_sw;

    always_comb begin
        after_sw = wr_stb ? apply_write(flags_q, wr_data) : flags_q;
    end

    // Hardware events are merged after the software update so they win.
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_t'(after_sw | hw_set_i);
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/sktchg_pin.sv
module sktchg_pin
    import sktchg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [NUM_GATE-1:0] gate_wdata,
    input  logic [1:0]          mode_wdata,
    input  flags_t              flags_i,
    output logic [DATA_W-1:0]   en_rd_o,
    output logic [NUM_GATE-1:0] gate_o,
    output logic [1:0]          mode_o,
    output logic                irq_level_o,
    output logic                irq_oe_o,
    output logic                irq_od_o
);
    logic [NUM_GATE-1:0] gate_q;
    pin_mode_e           mode_q;
    logic [NUM_GATE-1:0] gated_src;
    logic                req;
    pin_t                pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            mode_q <= PIN_HIZ;
        end else if (wr_stb) begin
            gate_q <= gate_wdata;
            mode_q <= pin_mode_e'(mode_wdata);
        end
    end

    assign gated_src = {flags_i.stat_chg, flags_i.error, flags_i.prog_tmr, flags_i.intlock};
    assign req       = |(gated_src & gate_q);

    always_comb begin
        pin = drive_pin(mode_q, req);
    end

    assign irq_level_o = pin.level;
    assign irq_oe_o    = pin.oe;
    assign irq_od_o    = pin.od;
    assign en_rd_o     = {1'b0, gate_q, 1'b0, mode_q};
    assign gate_o      = gate_q;
    assign mode_o      = mode_q;

endmodule

// File: rtl/sktchg_irq_ctrl.sv
module sktchg_irq_ctrl
    import sktchg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  reg_sel,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        card_det_i,
    input  logic        wprot_i,
    input  logic        ready_i,
    input  logic        batt2_i,
    input  logic        batt1_i,
    input  logic [4:0]  chg_mask_i,
    input  logic        ev_iochk_i,
    input  logic        ev_err_i,
    input  logic        ev_ptimer_i,
    input  logic        ev_ilock_i,
    input  logic        ev_stopcpu_i,
    output logic        irq_level_o,
    output logic        irq_oe_o,
    output logic        irq_od_o
);
    stat_t                raw_stat;
    logic [NUM_STAT-1:0]  stat_sync;
    logic [NUM_STAT-1:0]  stat_toggled;
    logic                 any_change;
    flags_t               hw_set;
    flags_t               flags_q;
    logic [DATA_W-1:0]    en_rd;
    logic [NUM_GATE-1:0]  gate_w;
    logic [1:0]           mode_w;
    logic                 flags_wr;
    logic                 enable_wr;

    assign raw_stat = '{card_det: card_det_i, wprot: wprot_i, ready: ready_i,
                        batt2: batt2_i, batt1: batt1_i};

    sktchg_sync #(.WIDTH(NUM_STAT), .STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .raw_i     (raw_stat),
        .sync_o    (stat_sync),
        .toggled_o (stat_toggled)
    );

    assign any_change = |(stat_toggled & ~chg_mask_i);

    assign hw_set = '{io_check: ev_iochk_i, stat_chg: any_change, error: ev_err_i,
                      prog_tmr: ev_ptimer_i, intlock: ev_ilock_i, stop_cpu: ev_stopcpu_i};

    assign flags_wr  = wr_en && (reg_sel == SEL_FLAGS);
    assign enable_wr = wr_en && (reg_sel == SEL_ENABLE);

    sktchg_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (flags_wr),
        .wr_data  (wr_data),
        .hw_set_i (hw_set),
        .flags_o  (flags_q)
    );

    sktchg_pin u_pin (
        .clk         (clk),
        .rst         (rst),
        .wr_stb      (enable_wr),
        .gate_wdata  (wr_data[6:3]),
        .mode_wdata  (wr_data[1:0]),
        .flags_i     (flags_q),
        .en_rd_o     (en_rd),
        .gate_o      (gate_w),
        .mode_o      (mode_w),
        .irq_level_o (irq_level_o),
        .irq_oe_o    (irq_oe_o),
        .irq_od_o    (irq_od_o)
    );

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_STATUS: rd_data = {stat_sync, 3'b000};
            SEL_FLAGS:  rd_data = {flags_q, 2'b00};
            SEL_ENABLE: rd_data = en_rd;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/sktchg_irq_chk.sv
module sktchg_irq_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] reg_sel,
    input logic [7:0] wr_data,
    input logic [5:0] flags,
    input logic [5:0] hw_set,
    input logic [3:0] gate,
    input logic [1:0] mode,
    input logic       irq_level_o,
    input logic       irq_oe_o,
    input logic       irq_od_o
);
    logic flag_wr;
    logic req_view;
    assign flag_wr  = wr_en && (reg_sel == 2'd1);
    assign req_view = |(flags[4:1] & gate);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flags == 6'd0 && gate == 4'd0 && mode == 2'd0 && !irq_oe_o));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[1:0] == 2'b11 && hw_set == 6'd0) |=> (flags == $past(wr_data[7:2])));

    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[1:0] == 2'b01 && hw_set == 6'd0) |=> ((flags & $past(wr_data[7:2])) == 6'd0));

    p_set_r5: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_data[1:0] == 2'b10) |=> ((flags & $past(wr_data[7:2])) == $past(wr_data[7:2])));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        ((!flag_wr || wr_data[1:0] == 2'b00) && hw_set == 6'd0) |=> (flags == $past(flags)));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (hw_set != 6'd0) |=> ((flags & $past(hw_set)) == $past(hw_set)));

    p_hiz_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> (!irq_oe_o && !irq_od_o && !irq_level_o));

    p_open_drain_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |-> (irq_od_o && !irq_level_o && (irq_oe_o == req_view)));

    p_active_high_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3) |-> (irq_oe_o && !irq_od_o && (irq_level_o == req_view)));

endmodule

bind sktchg_irq_ctrl sktchg_irq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .reg_sel     (reg_sel),
    .wr_data     (wr_data),
    .flags       (flags_q),
    .hw_set      (hw_set),
    .gate        (gate_w),
    .mode        (mode_w),
    .irq_level_o (irq_level_o),
    .irq_oe_o    (irq_oe_o),
    .irq_od_o    (irq_od_o)
);

// File: tb/sktchg_irq_ctrl_tb_top.sv
`timescale 1ns/100ps
module sktchg_irq_ctrl_tb_top;

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       card_det = 1'b1, wprot = 1'b0, ready = 1'b1, batt2 = 1'b0, batt1 = 1'b0;
    logic [4:0] chg_mask = 5'b00000;
    logic [4:0] ev = 5'b00000;   // 4 iochk, 3 err, 2 ptimer, 1 ilock, 0 stopcpu
    logic       irq_level, irq_oe, irq_od;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    sb_item_t sb_q[$];
    event push_ev;

    always #2.5 clk = ~clk;

    sktchg_irq_ctrl dut_i (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .card_det_i(card_det), .wprot_i(wprot), .ready_i(ready),
        .batt2_i(batt2), .batt1_i(batt1), .chg_mask_i(chg_mask),
        .ev_iochk_i(ev[4]), .ev_err_i(ev[3]), .ev_ptimer_i(ev[2]), .ev_ilock_i(ev[1]),
        .ev_stopcpu_i(ev[0]), .irq_level_o(irq_level), .irq_oe_o(irq_oe), .irq_od_o(irq_od)
    );

    // Monitor: pops expected items and compares them to the outputs.
    initial begin
        forever begin
            @(push_ev);
            #1;
            while (sb_q.size() > 0) begin
                sb_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = it.is_pin ? {5'b0, irq_level, irq_oe, irq_od} : rd_data;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] sel, input logic [7:0] exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        reg_sel = sel;
        it.is_pin = 1'b1 == 1'b0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        -> push_ev;
    endtask

    // Pin expectation is {level, oe, od}; called at a negedge.
    task automatic pin_chk(input logic [2:0] exp, input string tag);
        sb_item_t it;
        it.is_pin = 1'b1; it.exp = {5'b0, exp}; it.tag = tag;
        sb_q.push_back(it);
        -> push_ev;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        ev[idx] = 1'b1;
        @(negedge clk);
        ev = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(6);
        // R1 / R11: reset state, steady inputs raise nothing
        rd_chk(2'd1, 8'h00, "R1 R11 flags after reset");
        rd_chk(2'd2, 8'h00, "R1 enable after reset");
        pin_chk(3'b000, "R1 pin after reset");
        rd_chk(2'd0, 8'hA0, "R2 status view");

        // R3: write-protect rise, timed through the pin (gate bit6, mode 11)
        reg_write(2'd2, 8'h43);
        pin_chk(3'b010, "R9 idle active-high");
        @(negedge clk); wprot = 1'b1;
        tick(1); pin_chk(3'b010, "R3 no flag after one edge");
        tick(1); pin_chk(3'b010, "R3 no flag after two edges");
        tick(1); pin_chk(3'b110, "R3 flag on third edge");
        rd_chk(2'd0, 8'hE0, "R2 write protect bit 6");
        rd_chk(2'd1, 8'h40, "R3 change flag bit 6");
        reg_write(2'd1, 8'h41);
        pin_chk(3'b010, "R10 request drops after clear");

        // R3: ready falling and rising
        @(negedge clk); ready = 1'b0;
        tick(4);
        rd_chk(2'd1, 8'h40, "R3 ready falling");
        rd_chk(2'd0, 8'hC0, "R2 ready bit 5 low");
        reg_write(2'd1, 8'h41);
        @(negedge clk); ready = 1'b1;
        tick(4);
        rd_chk(2'd1, 8'h40, "R3 ready rising");
        reg_write(2'd1, 8'h41);

        // R4: masking
        chg_mask = 5'b11111;
        @(negedge clk); batt1 = 1'b1;
        tick(5);
        rd_chk(2'd1, 8'h00, "R4 masked battery change ignored");
        rd_chk(2'd0, 8'hE8, "R2 battery line 1 bit 3");
        chg_mask = 5'b01111;
        @(negedge clk); card_det = 1'b0;
        tick(5);
        rd_chk(2'd1, 8'h40, "R4 unmasked card detect");
        reg_write(2'd1, 8'h41);
        @(negedge clk); batt1 = 1'b0;
        tick(5);
        rd_chk(2'd1, 8'h00, "R4 battery still masked");
        rd_chk(2'd0, 8'h60, "R2 status after changes");

        // R5: qualifiers
        reg_write(2'd1, 8'hB2);
        rd_chk(2'd1, 8'hB0, "R5 set");
        reg_write(2'd1, 8'h0E);
        rd_chk(2'd1, 8'hBC, "R5 set accumulates");
        reg_write(2'd1, 8'h21);
        rd_chk(2'd1, 8'h9C, "R5 clear");
        reg_write(2'd1, 8'h43);
        rd_chk(2'd1, 8'h40, "R5 load");
        reg_write(2'd1, 8'hFC);
        rd_chk(2'd1, 8'h40, "R5 no qualifier no effect");
        reg_write(2'd1, 8'hFD);
        rd_chk(2'd1, 8'h00, "R5 clear all");

        // R6: event pulses
        pulse(3); rd_chk(2'd1, 8'h20, "R6 error event");
        reg_write(2'd1, 8'hFD);
        pulse(4); rd_chk(2'd1, 8'h80, "R6 io check event");
        reg_write(2'd1, 8'hFD);
        pulse(2); rd_chk(2'd1, 8'h10, "R6 program timer event");
        reg_write(2'd1, 8'hFD);
        pulse(1); rd_chk(2'd1, 8'h08, "R6 interlock event");
        reg_write(2'd1, 8'hFD);
        pulse(0); rd_chk(2'd1, 8'h04, "R6 stop cpu event");
        reg_write(2'd1, 8'hFD);

        // R7: event against clear and against load
        @(negedge clk);
        ev[1] = 1'b1; wr_en = 1'b1; reg_sel = 2'd1; wr_data = 8'hFD;
        @(negedge clk);
        ev = '0; wr_en = 1'b0;
        rd_chk(2'd1, 8'h08, "R7 event beats clear");
        @(negedge clk);
        ev[3] = 1'b1; wr_en = 1'b1; reg_sel = 2'd1; wr_data = 8'h03;
        @(negedge clk);
        ev = '0; wr_en = 1'b0;
        rd_chk(2'd1, 8'h20, "R7 event beats load");
        reg_write(2'd1, 8'hFD);

        // R8: gating and reserved bits
        reg_write(2'd2, 8'h23);
        reg_write(2'd1, 8'h0A);
        pin_chk(3'b010, "R8 ungated interlock no request");
        reg_write(2'd1, 8'h22);
        pin_chk(3'b110, "R8 gated error requests");
        reg_write(2'd2, 8'hFF);
        rd_chk(2'd2, 8'h7B, "R8 reserved bits read zero");

        // R10: deassert timing and ungated bits 7/2
        reg_write(2'd1, 8'h21);
        pin_chk(3'b110, "R10 interlock still requests");
        @(negedge clk);
        wr_en = 1'b1; reg_sel = 2'd1; wr_data = 8'h09;
        pin_chk(3'b110, "R10 still active before clear edge");
        @(negedge clk);
        wr_en = 1'b0;
        pin_chk(3'b010, "R10 inactive after clear edge");
        reg_write(2'd1, 8'h86);
        pin_chk(3'b010, "R10 bits 7 and 2 never request");
        rd_chk(2'd1, 8'h84, "R10 bits 7 and 2 set");
        reg_write(2'd1, 8'hFD);

        // R9: pin modes with request active, then inactive
        reg_write(2'd1, 8'h22);
        reg_write(2'd2, 8'h20); pin_chk(3'b000, "R9 hiz active");
        reg_write(2'd2, 8'h21); pin_chk(3'b011, "R9 open drain active");
        reg_write(2'd2, 8'h22); pin_chk(3'b010, "R9 low active");
        reg_write(2'd2, 8'h23); pin_chk(3'b110, "R9 high active");
        reg_write(2'd1, 8'h21);
        pin_chk(3'b010, "R9 high idle");
        reg_write(2'd2, 8'h21); pin_chk(3'b001, "R9 open drain idle");
        reg_write(2'd2, 8'h22); pin_chk(3'b110, "R9 low idle");
        reg_write(2'd2, 8'h20); pin_chk(3'b000, "R9 hiz idle");

        tick(2);
        #3;
        finish_run();
    end

endmodule